// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the software-visible register file of a four-channel DMA controller. A host programs it through sixteen 8-bit registers, selected by a 4-bit index and strobed by separate read and write pulses. Each channel holds a 16-bit base and current address and a 16-bit base and current count. It also holds a mask bit, an auto-init mode bit, an increment mode bit and a terminal-count flag.

All 16-bit values pass through the 8-bit port one byte at a time. A single byte pointer, shared by every channel, chooses the low or the high byte. The pointer flips on every address or count access. Software resets it with a dedicated command. Reading the status register reports the terminal-count flags and the live request lines, and clears the terminal-count flags as a side effect.

A transfer engine sits beside the block. It reads each channel's programmed state from flat output vectors. Through a strobe per channel it loads new current address and count values, and it raises terminal-count events. Writes to the command index (8) and the request index (9) are accepted and do nothing. Read data is combinational while the read strobe is high, and reads 0 otherwise. All state changes take effect at the clock edge that ends the access.

Top module: `dmareg_top`

## Requirements
- R1: A write to index 0, 2, 4 or 6 targets channel index/2. The byte goes into both the base and current address: into bits 7:0 when the byte pointer is 0, into bits 15:8 when it is 1.
- R2: A write to index 1, 3, 5 or 7 loads the base and current count of channel index/2, choosing the byte by the pointer in the same way as R1.
- R3: Every read or write of an index 0 to 7 flips the byte pointer. A read of an even index returns a byte of the current address, and a read of an odd index returns a byte of the current count: the low byte when the pointer is 0, the high byte when it is 1. The base value is never returned.
- R4: A write to index 0xA updates the mask of channel wdata[1:0]. wdata[2]=1 masks the channel and wdata[2]=0 unmasks it. The other channels keep their masks.
- R5: A write to index 0xB updates only channel wdata[1:0]. That channel's auto-init bit takes wdata[4] and its increment bit takes wdata[5].
- R6: A write to index 0xC sets the byte pointer to 0. A write to index 0xD masks all channels, clears every terminal-count flag (even one raised by the engine in the same cycle) and sets the pointer to 0.
- R7: A write to index 0xE unmasks all channels. A write to index 0xF sets the mask of channel n to wdata[n], for n = 0 to 3.
- R8: A read of index 8 returns the terminal-count flags in bits 3:0 and the request inputs in bits 7:4. After that read, all terminal-count flags are clear, except one that the engine sets in the same cycle.
- R9: After reset every channel is masked, increment is 1, auto-init is 0, every address and count is 0, every terminal-count flag is 0 and the pointer is 0.
- R10: A read of index 9 to 0xF returns 0xFF and changes no state. A write to index 8 or 9 changes no state.
- R11: An engine update strobe for channel n loads that channel's current address and count from the engine buses, and an engine terminal-count strobe sets its flag. A register write to channel n's address or count in the same cycle takes priority, and the engine's update to that channel is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, 0 when no read |
| eng_req | input | 4 | Per-channel request lines, reported in status |
| eng_tc_set | input | 4 | Per-channel terminal-count event |
| eng_upd | input | 4 | Per-channel current address/count load strobe |
| eng_addr | input | 16 | New current address for updated channels |
| eng_cnt | input | 16 | New current count for updated channels |
| ch_mask | output | 4 | Mask bit per channel |
| ch_autoinit | output | 4 | Auto-init bit per channel |
| ch_incr | output | 4 | Increment bit per channel |
| ch_tc | output | 4 | Terminal-count flag per channel |
| ch_base_addr | output | 64 | Base addresses, channel n at [16n+15:16n] |
| ch_cur_addr | output | 64 | Current addresses, same packing |
| ch_base_cnt | output | 64 | Base counts, same packing |
| ch_cur_cnt | output | 64 | Current counts, same packing |

## Verification
The hardest cases to reach are the collisions between the host side and the engine side. One is a status read or a master clear that lands in the same cycle as a terminal-count event. The other is a byte write that lands on a channel the engine is updating. Each also depends on where the shared byte pointer stands at that moment. Directed sequences line up these cases one cycle at a time. The bench then runs a seeded random mix of register accesses and engine strobes against a reference model kept in the bench. That mix carries the pointer into every phase of every collision and sweeps all sixteen indices.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int NCH    = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CH_W   = $clog2(NCH);

  localparam logic [3:0] IDX_STATUS  = 4'h8;
  localparam logic [3:0] IDX_MASK1   = 4'hA;
  localparam logic [3:0] IDX_MODE    = 4'hB;
  localparam logic [3:0] IDX_PTRCLR  = 4'hC;
  localparam logic [3:0] IDX_MCLR    = 4'hD;
  localparam logic [3:0] IDX_UNMASK  = 4'hE;
  localparam logic [3:0] IDX_MASKALL = 4'hF;

  // Replace one byte of a word; hi selects the upper byte
  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] w,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dmareg_ptr.sv
module dmareg_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clear,
  output logic ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= 1'b0;
    else if (clear)  ptr <= 1'b0;
    else if (toggle) ptr <= ~ptr;
  end

  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clear) |=> (ptr != $past(ptr))); // R3
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ptr); // R6
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              ptr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              upd,
  input  logic [WORD_W-1:0] upd_addr,
  input  logic [WORD_W-1:0] upd_cnt,
  input  logic              mask_we,
  input  logic              mask_val,
  input  logic              mode_we,
  input  logic              ai_val,
  input  logic              inc_val,
  input  logic              tc_set,
  input  logic              tc_clr,
  input  logic              tc_wipe,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] base_cnt,
  output logic [WORD_W-1:0] cur_cnt,
  output logic              mask,
  output logic              autoinit,
  output logic              incr,
  output logic              tc
);
  logic host_wr;
  logic eng_take;
  assign host_wr  = wr_addr | wr_cnt;
  assign eng_take = upd & ~host_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (wr_addr) begin
        base_addr <= merge_byte(base_addr, wdata, ptr);
        cur_addr  <= merge_byte(cur_addr, wdata, ptr);
      end
      if (wr_cnt) begin
        base_cnt <= merge_byte(base_cnt, wdata, ptr);
        cur_cnt  <= merge_byte(cur_cnt, wdata, ptr);
      end
      if (eng_take) begin
        cur_addr <= upd_addr;
        cur_cnt  <= upd_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= 1'b1;
      autoinit <= 1'b0;
      incr     <= 1'b1;
      tc       <= 1'b0;
    end else begin
      if (mask_we) mask <= mask_val;
      if (mode_we) begin
        autoinit <= ai_val;
        incr     <= inc_val;
      end
      if (tc_wipe)     tc <= 1'b0;
      else if (tc_set) tc <= 1'b1;
      else if (tc_clr) tc <= 1'b0;
    end
  end

  AST_TC_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set && !tc_wipe) |=> tc); // R8
  AST_TC_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    tc_wipe |=> !tc); // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && upd) |=> (cur_addr == base_addr) || ($past(cur_addr) != $past(base_addr))); // R11
  AST_ENG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !host_wr) |=> (cur_addr == $past(upd_addr)) && (cur_cnt == $past(upd_cnt))); // R11
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            reg_idx,
  input  logic [BYTE_W-1:0]     reg_wdata,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]        eng_req,
  input  logic [NCH-1:0]        eng_tc_set,
  input  logic [NCH-1:0]        eng_upd,
  input  logic [WORD_W-1:0]     eng_addr,
  input  logic [WORD_W-1:0]     eng_cnt,
  output logic [NCH-1:0]        ch_mask,
  output logic [NCH-1:0]        ch_autoinit,
  output logic [NCH-1:0]        ch_incr,
  output logic [NCH-1:0]        ch_tc,
  output logic [NCH*WORD_W-1:0] ch_base_addr,
  output logic [NCH*WORD_W-1:0] ch_cur_addr,
  output logic [NCH*WORD_W-1:0] ch_base_cnt,
  output logic [NCH*WORD_W-1:0] ch_cur_cnt
);
  // Decoded events, named for the assertions
  logic word_reg;
  logic byte_acc;
  logic ptr_clr;
  logic mclr;
  logic stat_rd;
  logic unmask_all;
  logic ptr;
  logic [CH_W-1:0] word_ch;
  logic [CH_W-1:0] cmd_ch;

  assign word_reg   = ~reg_idx[3];
  assign byte_acc   = (reg_wr | reg_rd) & word_reg;
  assign mclr       = reg_wr & (reg_idx == IDX_MCLR);
  assign ptr_clr    = mclr | (reg_wr & (reg_idx == IDX_PTRCLR));
  assign stat_rd    = reg_rd & ~reg_wr & (reg_idx == IDX_STATUS);
  assign unmask_all = reg_wr & (reg_idx == IDX_UNMASK);
  assign word_ch    = reg_idx[CH_W:1];
  assign cmd_ch     = reg_wdata[CH_W-1:0];

  dmareg_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (byte_acc),
    .clear  (ptr_clr),
    .ptr    (ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    logic wr_a, wr_c;
    logic m_we, m_val, md_we;

    assign sel  = (word_ch == c[CH_W-1:0]);
    assign wr_a = reg_wr & word_reg & sel & ~reg_idx[0];
    assign wr_c = reg_wr & word_reg & sel &  reg_idx[0];

    always_comb begin
      m_we  = 1'b0;
      m_val = 1'b0;
      if (reg_wr) begin
        unique case (reg_idx)
          IDX_MASK1:   begin m_we = (cmd_ch == c[CH_W-1:0]); m_val = reg_wdata[2]; end
          IDX_MCLR:    begin m_we = 1'b1; m_val = 1'b1; end
          IDX_UNMASK:  begin m_we = 1'b1; m_val = 1'b0; end
          IDX_MASKALL: begin m_we = 1'b1; m_val = reg_wdata[c]; end
          default:     begin m_we = 1'b0; m_val = 1'b0; end
        endcase
      end
    end
    assign md_we = reg_wr & (reg_idx == IDX_MODE) & (cmd_ch == c[CH_W-1:0]);

    dmareg_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (wr_a),
      .wr_cnt    (wr_c),
      .ptr       (ptr),
      .wdata     (reg_wdata),
      .upd       (eng_upd[c]),
      .upd_addr  (eng_addr),
      .upd_cnt   (eng_cnt),
      .mask_we   (m_we),
      .mask_val  (m_val),
      .mode_we   (md_we),
      .ai_val    (reg_wdata[4]),
      .inc_val   (reg_wdata[5]),
      .tc_set    (eng_tc_set[c]),
      .tc_clr    (stat_rd),
      .tc_wipe   (mclr),
      .base_addr (ch_base_addr[c*WORD_W +: WORD_W]),
      .cur_addr  (ch_cur_addr[c*WORD_W +: WORD_W]),
      .base_cnt  (ch_base_cnt[c*WORD_W +: WORD_W]),
      .cur_cnt   (ch_cur_cnt[c*WORD_W +: WORD_W]),
      .mask      (ch_mask[c]),
      .autoinit  (ch_autoinit[c]),
      .incr      (ch_incr[c]),
      .tc        (ch_tc[c])
    );
  end

  // Read path: current values only, byte chosen by the shared pointer
  logic [WORD_W-1:0] rd_word;
  always_comb begin
    rd_word = reg_idx[0] ? ch_cur_cnt[word_ch*WORD_W +: WORD_W]
                         : ch_cur_addr[word_ch*WORD_W +: WORD_W];
    reg_rdata = '0;
    if (reg_rd) begin
      if (word_reg)                      reg_rdata = pick_byte(rd_word, ptr);
      else if (reg_idx == IDX_STATUS)    reg_rdata = {eng_req, ch_tc};
      else                               reg_rdata = '1;
    end
  end

  AST_MCLR_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (&ch_mask) && (ch_tc == '0)); // R6
  AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_all |=> (ch_mask == '0)); // R7
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && eng_tc_set == '0) |=> (ch_tc == '0)); // R8
  AST_UNDEF_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_idx > IDX_STATUS) |-> (reg_rdata == '1)); // R10
  AST_UNDEF_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_idx > IDX_STATUS && eng_upd == '0 && eng_tc_set == '0)
      |=> $stable(ch_mask) && $stable(ch_tc) && $stable(ch_cur_addr)); // R10
endmodule

// File: tb/dmareg_top_bench.sv
module dmareg_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic [3:0]  eng_req = '0, eng_tc_set = '0, eng_upd = '0;
  logic [15:0] eng_addr = '0, eng_cnt = '0;
  logic [3:0]  ch_mask, ch_autoinit, ch_incr, ch_tc;
  logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareg_top u_dmareg_top (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .eng_req(eng_req), .eng_tc_set(eng_tc_set), .eng_upd(eng_upd),
    .eng_addr(eng_addr), .eng_cnt(eng_cnt),
    .ch_mask(ch_mask), .ch_autoinit(ch_autoinit), .ch_incr(ch_incr), .ch_tc(ch_tc),
    .ch_base_addr(ch_base_addr), .ch_cur_addr(ch_cur_addr),
    .ch_base_cnt(ch_base_cnt), .ch_cur_cnt(ch_cur_cnt)
  );

  // Reference model
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [3:0]  m_mask, m_ai, m_inc, m_tc;
  logic        m_ptr;
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [15:0] put8(logic [15:0] w, logic [7:0] b, logic hi);
    logic [15:0] r;
    r = w;
    if (hi) r[15:8] = b; else r[7:0] = b;
    return r;
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] i, logic [3:0] req);
    int c;
    logic [15:0] w;
    c = i / 2;
    if (i < 8) begin
      w = (i % 2 == 1) ? m_cc[c] : m_ca[c];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (i == 8) return {req, m_tc};
    return 8'hFF;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_ba[c] = '0; m_ca[c] = '0; m_bc[c] = '0; m_cc[c] = '0;
    end
    m_mask = 4'hF; m_ai = 4'h0; m_inc = 4'hF; m_tc = 4'h0; m_ptr = 1'b0;
  endtask

  task automatic check_state(string tag);
    logic [63:0] eba, eca, ebc, ecc;
    for (int c = 0; c < 4; c++) begin
      eba[c*16 +: 16] = m_ba[c]; eca[c*16 +: 16] = m_ca[c];
      ebc[c*16 +: 16] = m_bc[c]; ecc[c*16 +: 16] = m_cc[c];
    end
    checks++;
    if (ch_base_addr !== eba || ch_cur_addr !== eca || ch_base_cnt !== ebc ||
        ch_cur_cnt !== ecc || ch_mask !== m_mask || ch_autoinit !== m_ai ||
        ch_incr !== m_inc || ch_tc !== m_tc) begin
      fails++;
      $display("FAIL %s state: ba=%h ca=%h bc=%h cc=%h msk=%h ai=%h inc=%h tc=%h expected ba=%h ca=%h bc=%h cc=%h msk=%h ai=%h inc=%h tc=%h",
               tag, ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt, ch_mask, ch_autoinit,
               ch_incr, ch_tc, eba, eca, ebc, ecc, m_mask, m_ai, m_inc, m_tc);
    end
  endtask

  function automatic string tag_of(bit w, logic [3:0] i);
    if (i < 8) return (i % 2 == 0) ? (w ? "R1" : "R3") : (w ? "R2" : "R3");
    case (i)
      4'h8: return w ? "R10" : "R8";
      4'h9: return "R10";
      4'hA: return w ? "R4" : "R10";
      4'hB: return w ? "R5" : "R10";
      4'hC, 4'hD: return w ? "R6" : "R10";
      default: return w ? "R7" : "R10";
    endcase
  endfunction

  // One access cycle: drive at negedge, check read data, model at posedge
  task automatic cyc(bit w, bit r, logic [3:0] i, logic [7:0] d, logic [3:0] up,
                     logic [3:0] ts, logic [15:0] ea, logic [15:0] ec, logic [3:0] rq,
                     string tag);
    logic [7:0] exp;
    int c;
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_idx = i; reg_wdata = d;
    eng_upd = up; eng_tc_set = ts; eng_addr = ea; eng_cnt = ec; eng_req = rq;
    #1;
    if (r) begin
      exp = exp_read(i, rq);
      checks++;
      if (reg_rdata !== exp) begin
        fails++;
        $display("FAIL %s read idx %h: got %h expected %h", tag, i, reg_rdata, exp);
      end
    end
    @(posedge clk);
    c = i / 2;
    for (int k = 0; k < 4; k++)
      if (up[k] && !(w && i < 8 && c == k)) begin m_ca[k] = ea; m_cc[k] = ec; end
    if (w && i < 8) begin
      if (i % 2 == 0) begin m_ba[c] = put8(m_ba[c], d, m_ptr); m_ca[c] = put8(m_ca[c], d, m_ptr); end
      else            begin m_bc[c] = put8(m_bc[c], d, m_ptr); m_cc[c] = put8(m_cc[c], d, m_ptr); end
    end
    if (w) begin
      case (i)
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: begin m_ai[d[1:0]] = d[4]; m_inc[d[1:0]] = d[5]; end
        4'hD: m_mask = 4'hF;
        4'hE: m_mask = 4'h0;
        4'hF: m_mask = d[3:0];
        default: ;
      endcase
    end
    if (w && i == 4'hD) m_tc = 4'h0;
    else m_tc = ((r && !w && i == 8) ? 4'h0 : m_tc) | ts;
    if (w && (i == 4'hC || i == 4'hD)) m_ptr = 1'b0;
    else if ((w || r) && i < 8) m_ptr = ~m_ptr;
    #1;
    check_state(tag);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; eng_upd = '0; eng_tc_set = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_state("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R9");
    // R9: pointer at 0 after reset, read low byte of zero address
    cyc(0, 1, 4'h0, 8'h00, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 4'hC, 8'h00, 0, 0, 0, 0, 0, "R6");
    // R1/R2: low then high bytes
    cyc(1, 0, 4'h2, 8'h34, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 4'h2, 8'h12, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 4'h7, 8'hCD, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 4'h7, 8'hAB, 0, 0, 0, 0, 0, "R2");
    // R3: engine moves current away from base, reads return current
    cyc(0, 0, 4'h0, 8'h00, 4'b0010, 0, 16'h5A5A, 16'h0F0F, 0, "R11");
    cyc(0, 1, 4'h2, 8'h00, 0, 0, 0, 0, 0, "R3");
    cyc(0, 1, 4'h2, 8'h00, 0, 0, 0, 0, 0, "R3");
    // R11: host write wins over engine on same channel
    cyc(1, 0, 4'h3, 8'h77, 4'b0011, 0, 16'h1111, 16'h2222, 0, "R11");
    // R4/R5/R7
    cyc(1, 0, 4'hE, 8'h00, 0, 0, 0, 0, 0, "R7");
    cyc(1, 0, 4'hA, 8'h06, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 4'hB, 8'h11, 0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 4'hF, 8'hF5, 0, 0, 0, 0, 0, "R7");
    // R8: status read clears, but same-cycle set survives
    cyc(0, 0, 4'h0, 8'h00, 0, 4'b1011, 0, 0, 0, "R11");
    cyc(0, 1, 4'h8, 8'h00, 0, 4'b0100, 0, 0, 4'b1001, "R8");
    cyc(0, 1, 4'h8, 8'h00, 0, 0, 0, 0, 4'b0110, "R8");
    // R10: undefined read, ignored writes
    cyc(0, 1, 4'h9, 8'h00, 0, 0, 0, 0, 0, "R10");
    cyc(0, 1, 4'hF, 8'h00, 0, 0, 0, 0, 0, "R10");
    cyc(1, 0, 4'h8, 8'hFF, 0, 0, 0, 0, 0, "R10");
    cyc(1, 0, 4'h9, 8'hFF, 0, 0, 0, 0, 0, "R10");
    // R6: master clear beats a same-cycle terminal count, pointer reset
    cyc(1, 0, 4'h0, 8'h99, 0, 0, 0, 0, 0, "R1");
    cyc(1, 0, 4'hD, 8'h00, 0, 4'b1111, 0, 0, 0, "R6");
    cyc(0, 1, 4'h0, 8'h00, 0, 0, 0, 0, 0, "R6");
    // Random mix
    seed = 32'h5EED;
    void'($urandom(seed));
    for (int n = 0; n < 600; n++) begin
      bit w, r;
      logic [3:0] i;
      int k;
      k = $urandom_range(0, 9);
      w = (k < 5);
      r = (k >= 5 && k < 8);
      i = 4'($urandom_range(0, 15));
      if (k >= 8) i = 4'($urandom_range(0, 7));
      cyc(w, r, i, 8'($urandom), 4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
          16'($urandom), 16'($urandom), 4'($urandom), (w || r) ? tag_of(w, i) : "R11");
    end
    finish_run();
  end
endmodule